// File: doc/BRIEF.md
# Wiper Register Controller With Nonvolatile Shadow

This block holds the digital state behind a tap-selected resistor divider. A working wiper register drives the tap code. A stored register holds the code the wiper takes after power-up. A control register carries a mode bit, a run bit and a read-only busy flag. The block sits behind a serial slave front end, which hands it one decoded register request at a time. It also receives a pulse each time chip select rises at the end of a transaction.

Address 0 is shared by the working and the stored register. When the mode bit is set, only the working register is touched. When it is clear, a write goes to both registers, and a read returns the stored value. A stored write becomes permanent only through a timed busy cycle, which starts when chip select rises; while that cycle runs, every write is refused. At power-up the wiper first sits at midscale and then, after a recall delay, takes the stored value. A soft power-cycle input restarts the volatile state and leaves the stored value alone. An active-low pin and the run bit together decide whether the divider is shut down.

Top module: `wiper_ctrl`

## Requirements
- R1: The control register is at address 2'b10. Its read format is bit 7 = mode, bit 6 = run, bit 5 = busy, and bits [4:0] = 0. Writes change only the mode and run bits.
- R2: After a hard reset or a soft power cycle, mode = 0 and run = 1, so the control register reads 8'h40.
- R3: With mode = 1, an address-0 write updates only the working register and starts no busy cycle. An address-0 read returns the working code, zero-extended (bit 7 = 0).
- R4: With mode = 0, an address-0 write sets the working register at once and marks the value for storage. An address-0 read returns the stored value and leaves the working register unchanged.
- R5: A chip-select rise after such a write holds busy = 1 for NV_CYCLES clocks. During that time every write is refused. The stored value takes the new code when the cycle ends.
- R6: On power-up the wiper is 7'h40 (midscale). After RECALL_CYCLES clocks it takes the stored value. A hard reset sets the stored value to IVR_INIT (default 7'h2A).
- R7: The block is shut down when shdn_n_i is low or run = 0. In shutdown, shutdown_o = 1 and wiper_o = 7'h00.
- R8: All registers can be read and written during shutdown. On leaving shutdown, wiper_o shows the working register again.
- R9: Writes to address 2'b01 are ignored, and reads from it return 8'h00. Address 2'b11 aliases the control register when ALIAS_ALT = 1 (the default).
- R10: A soft power cycle keeps the stored value. If it comes during a busy cycle, the cycle is aborted and the previous stored value stays.
- R11: Read and write requests that arrive before the power-up recall completes are ignored.
- R12: When running, wiper_o equals the working code: 7'h00 is the ground end and 7'h7F is the supply end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Hard reset, active low; also clears the stored value |
| pwr_cycle_i | input | 1 | Soft power cycle; restarts the volatile state |
| req_valid_i | input | 1 | Register request strobe from the serial front end |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 2 | Register address |
| req_wdata_i | input | 8 | Write data byte |
| cs_rise_i | input | 1 | Pulse when chip select rises |
| shdn_n_i | input | 1 | Shutdown pin, active low |
| rd_data_o | output | 8 | Read data, valid the clock after a read request |
| wiper_o | output | 7 | Tap code driven to the resistor array |
| shutdown_o | output | 1 | 1 while the divider is shut down |

## Verification
The hardest state to reach from the ports is a power cycle that lands in the middle of a stored-write busy cycle. To get there, the bench writes a new code with mode = 0, raises chip select and waits a few clocks. It then pulses the soft power cycle while busy is still 1. After the recall it checks both the wiper and an address-0 read against the old stored code. Write refusal is checked the same way, inside a live busy window: the bench makes a wiper write and a control write there and reads both registers back.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
   typedef enum logic [1:0] {
      ADDR_WIPER = 2'b00,
      ADDR_RSVD  = 2'b01,
      ADDR_CTRL  = 2'b10,
      ADDR_ALT   = 2'b11
   } wpc_addr_e;

   localparam int CTRL_MODE_BIT = 7;
   localparam int CTRL_RUN_BIT  = 6;
   localparam int CTRL_BUSY_BIT = 5;
   localparam int BYTE_W        = 8;
endpackage

// File: rtl/wpc_cycle_timer.sv
module wpc_cycle_timer #(
   parameter int COUNT      = 200,
   parameter bit START_BUSY = 1'b0
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic clear_i,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   localparam int CW = $clog2(COUNT + 1);
   localparam logic [CW-1:0] FULL = CW'(COUNT);
   localparam logic [CW-1:0] IDLE_VAL = START_BUSY ? FULL : '0;

   logic [CW-1:0] cnt_q;

   initial begin
      assert (COUNT >= 2) else $error("timer COUNT must be at least 2");
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)           cnt_q <= IDLE_VAL;
      else if (clear_i)       cnt_q <= IDLE_VAL;
      else if (start_i)       cnt_q <= FULL;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);
   assign done_o = (cnt_q == CW'(1));

   assert_busy_start_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (start_i && !clear_i) |=> busy_o);
   assert_busy_count_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (busy_o && !clear_i && !start_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/wpc_addr_decode.sv
module wpc_addr_decode import wpc_pkg::*; #(
   parameter bit ALIAS_ALT = 1'b1
) (
   input  logic [1:0] addr_i,
   output logic       sel_wiper_o,
   output logic       sel_ctrl_o
);
   assign sel_wiper_o = (addr_i == ADDR_WIPER);
   generate
      if (ALIAS_ALT) begin : g_alias
         assign sel_ctrl_o = (addr_i == ADDR_CTRL) || (addr_i == ADDR_ALT);
      end else begin : g_strict
         assign sel_ctrl_o = (addr_i == ADDR_CTRL);
      end
   endgenerate
endmodule

// File: rtl/wpc_regs.sv
module wpc_regs #(
   parameter int WIPER_W  = 7,
   parameter int IVR_INIT = 'h2A
) (
   input  logic               clk_i,
   input  logic               rst_n_i,
   input  logic               pwr_cycle_i,
   input  logic               ready_i,
   input  logic               recall_done_i,
   input  logic               req_valid_i,
   input  logic               req_write_i,
   input  logic               sel_wiper_i,
   input  logic               sel_ctrl_i,
   input  logic [7:0]         wdata_i,
   input  logic               cs_rise_i,
   input  logic               nv_busy_i,
   input  logic               nv_done_i,
   output logic               nv_start_o,
   output logic [WIPER_W-1:0] wr_o,
   output logic [WIPER_W-1:0] ivr_o,
   output logic               mode_o,
   output logic               run_o
);
   localparam logic [WIPER_W-1:0] MID_CODE = WIPER_W'(1) << (WIPER_W - 1);
   localparam logic [WIPER_W-1:0] IVR_RST  = WIPER_W'(IVR_INIT);

   logic [WIPER_W-1:0] wr_q, ivr_q, stage_q;
   logic pend_q, mode_q, run_q;
   logic accept, wiper_wr, ctrl_wr;

   assign accept     = req_valid_i && req_write_i && ready_i && !nv_busy_i && !pwr_cycle_i;
   assign wiper_wr   = accept && sel_wiper_i;
   assign ctrl_wr    = accept && sel_ctrl_i;
   assign nv_start_o = cs_rise_i && pend_q && ready_i && !nv_busy_i && !pwr_cycle_i;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         wr_q    <= MID_CODE;
         mode_q  <= 1'b0;
         run_q   <= 1'b1;
         pend_q  <= 1'b0;
         stage_q <= '0;
      end else if (pwr_cycle_i) begin
         wr_q    <= MID_CODE;
         mode_q  <= 1'b0;
         run_q   <= 1'b1;
         pend_q  <= 1'b0;
      end else begin
         if (recall_done_i)  wr_q <= ivr_q;
         else if (wiper_wr)  wr_q <= wdata_i[WIPER_W-1:0];
         if (wiper_wr && !mode_q) begin
            stage_q <= wdata_i[WIPER_W-1:0];
            pend_q  <= 1'b1;
         end else if (nv_start_o) begin
            pend_q  <= 1'b0;
         end
         if (ctrl_wr) begin
            mode_q <= wdata_i[wpc_pkg::CTRL_MODE_BIT];
            run_q  <= wdata_i[wpc_pkg::CTRL_RUN_BIT];
         end
      end
   end

   // stored value: only a hard reset or a completed busy cycle changes it
   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)                      ivr_q <= IVR_RST;
      else if (nv_done_i && !pwr_cycle_i) ivr_q <= stage_q;
   end

   assign wr_o   = wr_q;
   assign ivr_o  = ivr_q;
   assign mode_o = mode_q;
   assign run_o  = run_q;

   assert_write_lock_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (nv_busy_i && req_valid_i && req_write_i && !pwr_cycle_i && !recall_done_i)
      |=> ($stable(wr_q) && $stable(mode_q) && $stable(run_q)));
   assert_ivr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!nv_done_i || pwr_cycle_i) |=> $stable(ivr_q));
   assert_midscale_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      pwr_cycle_i |=> (wr_q == MID_CODE));
   assert_recall_load_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (recall_done_i && !pwr_cycle_i) |=> (wr_q == $past(ivr_q)));
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl import wpc_pkg::*; #(
   parameter int WIPER_W       = 7,
   parameter int NV_CYCLES     = 200,
   parameter int RECALL_CYCLES = 30,
   parameter int IVR_INIT      = 'h2A,
   parameter bit ALIAS_ALT     = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_n_i,
   input  logic               pwr_cycle_i,
   input  logic               req_valid_i,
   input  logic               req_write_i,
   input  logic [1:0]         req_addr_i,
   input  logic [7:0]         req_wdata_i,
   input  logic               cs_rise_i,
   input  logic               shdn_n_i,
   output logic [7:0]         rd_data_o,
   output logic [WIPER_W-1:0] wiper_o,
   output logic               shutdown_o
);
   initial begin
      assert (WIPER_W >= 1 && WIPER_W <= 7) else $error("WIPER_W must fit below the byte MSB");
      assert (IVR_INIT >= 0 && IVR_INIT < (1 << WIPER_W)) else $error("IVR_INIT out of range");
   end

   logic recall_busy, recall_done, ready;
   logic nv_busy, nv_done, nv_start;
   logic sel_wiper, sel_ctrl;
   logic [WIPER_W-1:0] wr, ivr;
   logic mode, run;
   logic [7:0] rd_next, rd_q;
   logic rd_take;

   wpc_cycle_timer #(.COUNT(RECALL_CYCLES), .START_BUSY(1'b1)) u_recall (
      .clk_i(clk_i), .rst_n_i(rst_n_i), .clear_i(pwr_cycle_i), .start_i(1'b0),
      .busy_o(recall_busy), .done_o(recall_done));

   wpc_cycle_timer #(.COUNT(NV_CYCLES), .START_BUSY(1'b0)) u_nvwrite (
      .clk_i(clk_i), .rst_n_i(rst_n_i), .clear_i(pwr_cycle_i), .start_i(nv_start),
      .busy_o(nv_busy), .done_o(nv_done));

   assign ready = !recall_busy;

   wpc_addr_decode #(.ALIAS_ALT(ALIAS_ALT)) u_dec (
      .addr_i(req_addr_i), .sel_wiper_o(sel_wiper), .sel_ctrl_o(sel_ctrl));

   wpc_regs #(.WIPER_W(WIPER_W), .IVR_INIT(IVR_INIT)) u_regs (
      .clk_i(clk_i), .rst_n_i(rst_n_i), .pwr_cycle_i(pwr_cycle_i),
      .ready_i(ready), .recall_done_i(recall_done),
      .req_valid_i(req_valid_i), .req_write_i(req_write_i),
      .sel_wiper_i(sel_wiper), .sel_ctrl_i(sel_ctrl), .wdata_i(req_wdata_i),
      .cs_rise_i(cs_rise_i), .nv_busy_i(nv_busy), .nv_done_i(nv_done),
      .nv_start_o(nv_start), .wr_o(wr), .ivr_o(ivr), .mode_o(mode), .run_o(run));

   always_comb begin
      rd_next = '0;
      if (sel_wiper) begin
         rd_next = 8'(mode ? wr : ivr);
      end else if (sel_ctrl) begin
         rd_next[CTRL_MODE_BIT] = mode;
         rd_next[CTRL_RUN_BIT]  = run;
         rd_next[CTRL_BUSY_BIT] = nv_busy;
      end
   end

   assign rd_take = req_valid_i && !req_write_i && ready && !pwr_cycle_i;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)         rd_q <= '0;
      else if (pwr_cycle_i) rd_q <= '0;
      else if (rd_take)     rd_q <= rd_next;
   end

   assign rd_data_o  = rd_q;
   assign shutdown_o = !shdn_n_i || !run;
   assign wiper_o    = shutdown_o ? '0 : wr;

   assert_ctrl_low_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (rd_take && sel_ctrl) |=> (rd_data_o[4:0] == 5'b0));
   assert_pin_shutdown_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !shdn_n_i |-> (wiper_o == '0));
   assert_busy_needs_ready_R11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(nv_busy) |-> $past(ready));
endmodule

// File: tb/tb_wiper_ctrl.sv
module tb_wiper_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 200;
   localparam int RC = 30;

   logic clk = 0, rst_n = 0, pwr = 0, rv = 0, rw = 0, cs = 0, shdn_n = 1;
   logic [1:0] addr = '0;
   logic [7:0] wd = '0;
   logic [7:0] rd;
   logic [6:0] wiper;
   logic shut;
   int checks = 0, errors = 0, cyc = 0;
   bit finished = 0;
   logic [7:0] d;

   wiper_ctrl #(.NV_CYCLES(NV), .RECALL_CYCLES(RC)) dut (
      .clk_i(clk), .rst_n_i(rst_n), .pwr_cycle_i(pwr), .req_valid_i(rv),
      .req_write_i(rw), .req_addr_i(addr), .req_wdata_i(wd), .cs_rise_i(cs),
      .shdn_n_i(shdn_n), .rd_data_o(rd), .wiper_o(wiper), .shutdown_o(shut));

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog act=%0d exp=<150000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wreq(logic [1:0] a, logic [7:0] v);
      @(negedge clk); rv = 1; rw = 1; addr = a; wd = v;
      @(negedge clk); rv = 0; rw = 0;
   endtask

   task automatic rreq(logic [1:0] a, output logic [7:0] v);
      @(negedge clk); rv = 1; rw = 0; addr = a;
      @(negedge clk); rv = 0; v = rd;
   endtask

   task automatic cs_pulse();
      @(negedge clk); cs = 1;
      @(negedge clk); cs = 0;
   endtask

   task automatic pwr_pulse();
      @(negedge clk); pwr = 1;
      @(negedge clk); pwr = 0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R6 midscale after reset", wiper, 'h40);
      chk("R7 not shut after reset", shut, 0);
      idle(RC + 2);
      chk("R6 recalled IVR_INIT", wiper, 'h2A);
      rreq(2'b10, d); chk("R2 ctrl default", d, 'h40);
   endtask

   task automatic t_volatile();
      wreq(2'b10, 8'hC0);
      rreq(2'b10, d); chk("R1 ctrl readback", d, 'hC0);
      wreq(2'b00, 8'h11); chk("R3 wiper write", wiper, 'h11);
      rreq(2'b00, d); chk("R3 read zero-extended", d, 'h11);
      cs_pulse(); idle(1);
      rreq(2'b10, d); chk("R3 no busy cycle", d, 'hC0);
      wreq(2'b00, 8'h7F); chk("R12 supply end", wiper, 'h7F);
      wreq(2'b00, 8'h00); chk("R12 ground end", wiper, 'h00);
      wreq(2'b10, 8'h40);
      rreq(2'b00, d); chk("R3 stored untouched", d, 'h2A);
   endtask

   task automatic t_nv();
      wreq(2'b00, 8'h77); chk("R4 wiper set at once", wiper, 'h77);
      rreq(2'b00, d); chk("R4 stored before cycle", d, 'h2A);
      cs_pulse();
      rreq(2'b10, d); chk("R5 busy set", d, 'h60);
      wreq(2'b00, 8'h05); chk("R5 wiper write refused", wiper, 'h77);
      wreq(2'b10, 8'hC0);
      rreq(2'b10, d); chk("R5 ctrl write refused", d, 'h60);
      idle(NV + 5);
      rreq(2'b10, d); chk("R5 busy cleared", d, 'h40);
      rreq(2'b00, d); chk("R5 stored committed", d, 'h77);
      wreq(2'b10, 8'hC0); wreq(2'b00, 8'h10); wreq(2'b10, 8'h40);
      rreq(2'b00, d); chk("R4 read returns stored", d, 'h77);
      chk("R4 read leaves wiper", wiper, 'h10);
   endtask

   task automatic t_power();
      pwr_pulse();
      chk("R6 midscale after cycle", wiper, 'h40);
      idle(RC + 2);
      chk("R10 stored kept", wiper, 'h77);
      rreq(2'b10, d); chk("R2 ctrl after cycle", d, 'h40);
   endtask

   task automatic t_shutdown();
      wreq(2'b10, 8'hC0);
      @(negedge clk); shdn_n = 0; #1;
      chk("R7 pin shutdown flag", shut, 1);
      chk("R7 pin wiper ground", wiper, 0);
      wreq(2'b00, 8'h33);
      rreq(2'b00, d); chk("R8 write in shutdown", d, 'h33);
      @(negedge clk); shdn_n = 1; #1;
      chk("R8 wiper restored", wiper, 'h33);
      wreq(2'b10, 8'h80); chk("R7 run bit shutdown", shut, 1);
      chk("R7 run bit wiper ground", wiper, 0);
      wreq(2'b10, 8'hC0); chk("R8 run restored", wiper, 'h33);
   endtask

   task automatic t_reserved();
      wreq(2'b01, 8'h5A);
      chk("R9 reserved write ignored", wiper, 'h33);
      rreq(2'b01, d); chk("R9 reserved reads zero", d, 0);
      rreq(2'b11, d); chk("R9 alias reads ctrl", d, 'hC0);
   endtask

   task automatic t_abort();
      wreq(2'b10, 8'h40);
      wreq(2'b00, 8'h3C);
      cs_pulse(); idle(5);
      pwr_pulse(); idle(RC + 2);
      chk("R10 abort keeps old stored", wiper, 'h77);
      rreq(2'b10, d); chk("R10 busy aborted", d, 'h40);
      rreq(2'b00, d); chk("R10 stored read", d, 'h77);
   endtask

   task automatic t_recall_block();
      pwr_pulse();
      wreq(2'b00, 8'h01);
      cs_pulse();
      idle(RC + 2);
      chk("R11 write in recall ignored", wiper, 'h77);
      rreq(2'b10, d); chk("R11 no busy started", d, 'h40);
   endtask

   initial begin
      idle(3);
      @(negedge clk); rst_n = 1; #1;
      t_reset();
      t_volatile();
      t_nv();
      t_power();
      t_shutdown();
      t_reserved();
      t_abort();
      t_recall_block();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule